// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

This block is one 32-bit timer channel with a four-word register interface. A live count register decrements once per prescaler tick while an external run input is high. The prescaler divides the clock by a power of four, chosen by a 3-bit field in the control register. When a tick finds the count at zero, the channel loads the value held in a separate reload register and raises a sticky underflow flag.

Software clears the flag by writing zero to its control bit. Writing one to that bit changes nothing, so software cannot set the flag. The interrupt line is the flag gated by an enable bit in the control register. Fields for clock-edge select and input capture are held in the control register but have no effect on counting. An optional capture register, chosen by a parameter, sits at word 3.

Top module: `dctmr_channel`

## Requirements
- R1: After reset the reload and count registers read 0xFFFFFFFF, the control register reads 0, and irq is 0.
- R2: Word addresses are: 0 for reload, 1 for count, 2 for control and 3 for capture. rdata shows the addressed register one clock after addr is presented. With HAS_CAPTURE=1, word 3 stores a full 32-bit write. With HAS_CAPTURE=0, word 3 reads 0 and writes to it are ignored.
- R3: Control bits [2:0] select the divide ratio. Values 0, 1, 2, 3 and 4 give one decrement per 4, 16, 64, 256 and 1024 rising edges with run high. The first decrement comes on exactly the divisor-th such edge.
- R4: Selection values 5, 6 and 7 produce no decrements.
- R5: While run is low the count holds and the prescaler is cleared, so every restart waits a full divided period before the first decrement.
- R6: A tick that finds the count at 0 loads the reload value into the count and sets the underflow flag (control bit 8) in the same cycle.
- R7: A control write with bit 8 = 0 clears the flag. A control write with bit 8 = 1 leaves the flag as it was, and never sets it.
- R8: A control read returns the stored bits [7:0] (bits [2:0] select, [4:3] edge select, 5 interrupt enable, [7:6] capture enable), the flag in bit 8, and 0 in bits [31:9].
- R9: irq is 1 exactly when the flag is set and control bit 5 is 1.
- R10: A count write loads the counter directly. A reload write takes effect at the next underflow. A count write in the same cycle as an underflow wins over the reload, and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Counting enable from the external start register |
| addr | input | 2 | Word index of the register being read or written |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | W | Write data |
| rdata | output | W | Registered read data for the addressed register |
| irq | output | 1 | Underflow interrupt: flag AND enable |

## Verification
The assertions assume that addr and wdata are stable and well defined whenever wr_en is high. They also assume that run changes only between clock edges, so the prescaler sees a clean level. The bench drives every input on the falling edge and holds addr steady for the whole read cycle, which keeps within these assumptions. The bench reads the live count only while run is low, so a sampled value never depends on a tick arriving in the same cycle as the read. The single deliberate overlap is the count write on an underflow tick, and its edge is placed by counting run edges.

// File: rtl/dctmr_pkg.sv
package dctmr_pkg;
  typedef enum logic [1:0] {
    IDX_RELOAD = 2'd0,
    IDX_COUNT  = 2'd1,
    IDX_CTRL   = 2'd2,
    IDX_CAPT   = 2'd3
  } reg_idx_e;

  localparam int unsigned SEL_W      = 3;
  localparam int unsigned CTRL_KEEP  = 8;   // stored control bits [7:0]
  localparam int unsigned IE_BIT     = 5;
  localparam int unsigned FLAG_BIT   = 8;
  localparam int unsigned PRE_STEPS  = 5;   // number of legal divide ratios
endpackage

// File: rtl/dctmr_prescale.sv
module dctmr_prescale #(
  parameter int unsigned STEPS = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PW = 2 * STEPS;

  logic [PW-1:0] pre_q;
  logic [PW-1:0] mask;
  logic          sel_ok;

  always_comb begin
    sel_ok = (32'(sel) < STEPS);
    mask   = ~({PW{1'b1}} << (2 * (32'(sel) + 1)));
    tick   = run && sel_ok && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  // R5
  restart_wait_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> !tick);
endmodule

// File: rtl/dctmr_counter.sv
module dctmr_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         cnt_we,
  input  logic         rld_we,
  input  logic [W-1:0] wdata,
  input  logic         flag_clr,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] rld_q,
  output logic         flag_q
);
  logic underflow;
  assign underflow = tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
      rld_q <= '1;
    end else begin
      if (rld_we) rld_q <= wdata;
      if (cnt_we)         cnt_q <= wdata;
      else if (underflow) cnt_q <= rld_q;
      else if (tick)      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           flag_q <= 1'b0;
    else if (underflow) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cnt_we) |=> $stable(cnt_q));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  // R6
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !cnt_we && cnt_q == '0) |=> (cnt_q == $past(rld_q)) && flag_q);
  // R6
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick && cnt_q == '0));
endmodule

// File: rtl/dctmr_channel.sv
module dctmr_channel
  import dctmr_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter bit          HAS_CAPTURE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int unsigned PAD_W = W - CTRL_KEEP - 1;

  logic [CTRL_KEEP-1:0] ctrl_q;
  logic [W-1:0]         cnt_q, rld_q, capt_q;
  logic                 flag_q, tick;
  logic                 wr_rld, wr_cnt, wr_ctrl, wr_capt;

  always_comb begin
    wr_rld  = wr_en && (addr == IDX_RELOAD);
    wr_cnt  = wr_en && (addr == IDX_COUNT);
    wr_ctrl = wr_en && (addr == IDX_CTRL);
    wr_capt = wr_en && (addr == IDX_CAPT);
  end

  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= wdata[CTRL_KEEP-1:0];
  end

  generate
    if (HAS_CAPTURE) begin : g_capt
      always_ff @(posedge clk) begin
        if (rst)          capt_q <= '0;
        else if (wr_capt) capt_q <= wdata;
      end
    end else begin : g_nocapt
      assign capt_q = '0;
    end
  endgenerate

  dctmr_prescale #(.STEPS(PRE_STEPS), .SEL_W(SEL_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (ctrl_q[SEL_W-1:0]),
    .tick (tick)
  );

  dctmr_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cnt_we   (wr_cnt),
    .rld_we   (wr_rld),
    .wdata    (wdata),
    .flag_clr (wr_ctrl && !wdata[FLAG_BIT]),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .flag_q   (flag_q)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      case (addr)
        IDX_RELOAD: rdata <= rld_q;
        IDX_COUNT:  rdata <= cnt_q;
        IDX_CTRL:   rdata <= {{PAD_W{1'b0}}, flag_q, ctrl_q};
        default:    rdata <= capt_q;
      endcase
    end
  end

  assign irq = flag_q && ctrl_q[IE_BIT];

  // R7
  flag_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !flag_q && !tick) |=> !flag_q);
endmodule

// File: tb/sim_dctmr_channel.sv
module sim_dctmr_channel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dctmr_channel #(.W(32), .HAS_CAPTURE(1'b1)) u0 (
    .clk(clk), .rst(rst), .run(run), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  localparam int NV = 12;
  localparam int V_SEL  [NV] = '{0,   0,   0,  1,  1,  2,   3,    4,    4,   5,   6,   7};
  localparam int V_START[NV] = '{100, 100, 100, 50, 50, 10, 10,   10,   10,  10,  10,  10};
  localparam int V_RUN  [NV] = '{4,   3,   40, 16, 47, 64, 256, 1024, 1023, 100, 100, 100};
  localparam int V_EXP  [NV] = '{99,  100, 90, 49, 48, 9,  9,    9,    10,  10,  10,  10};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic run_for(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(2'd0, v); chk("R1 reload", v, 32'hFFFF_FFFF);
    rd(2'd1, v); chk("R1 count", v, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R1 control", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // R3 R4 divide ratios from table
    for (int i = 0; i < NV; i++) begin
      wr(2'd2, 32'(V_SEL[i]));
      wr(2'd1, 32'(V_START[i]));
      run_for(V_RUN[i]);
      rd(2'd1, v);
      chk((V_SEL[i] > 4) ? "R4 no-tick select" : "R3 divide", v, 32'(V_EXP[i]));
    end

    // R2 capture register
    wr(2'd3, 32'h1234_5678);
    rd(2'd3, v); chk("R2 capture", v, 32'h1234_5678);

    // R7 R8 writing ones cannot set flag; bits above 7 read 0
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk("R7 R8 control all-ones", v, 32'h0000_00FF);

    // R5 pause clears prescaler
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd20);
    run_for(2); run_for(2);
    rd(2'd1, v); chk("R5 paused restart", v, 32'd20);
    run_for(4);
    rd(2'd1, v); chk("R5 full period", v, 32'd19);

    // R6 R9 underflow reload and interrupt
    wr(2'd2, 32'h20);
    wr(2'd0, 32'd5);
    wr(2'd1, 32'd1);
    run_for(8);
    rd(2'd1, v); chk("R6 reload on underflow", v, 32'd5);
    rd(2'd2, v); chk("R8 flag in bit 8", v, 32'h120);
    chk("R9 irq set", {31'd0, irq}, 32'd1);

    wr(2'd2, 32'h120);
    rd(2'd2, v); chk("R7 write one keeps flag", v, 32'h120);
    wr(2'd2, 32'h100);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h020);
    rd(2'd2, v); chk("R7 write zero clears", v, 32'h020);
    chk("R9 irq after clear", {31'd0, irq}, 32'd0);

    // R10 reload write applies at next underflow
    wr(2'd0, 32'd9);
    wr(2'd1, 32'd0);
    run_for(4);
    rd(2'd1, v); chk("R10 new reload", v, 32'd9);

    // R10 count write on the underflow edge wins
    wr(2'd2, 32'h0);
    wr(2'd1, 32'd0);
    @(negedge clk);
    run = 1'b1;
    repeat (3) @(negedge clk);
    addr = 2'd1; wdata = 32'h77; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; run = 1'b0;
    rd(2'd1, v); chk("R10 write beats reload", v, 32'h77);
    rd(2'd2, v); chk("R10 flag still set", v, 32'h100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule